// File: doc/BRIEF.md
# Serial Receive Byte Aligner

This block assembles a bit-serial receive stream into whole bytes. It runs entirely on one free-running system clock. The receive line clock arrives as a per-cycle enable, `bit_en`. That enable may drop for any number of cycles, for example across framing overhead or when the line runs at a fractional rate, and the block simply waits while it is low. Bits arrive most-significant first. Each finished byte is presented on `byte_out`, with `byte_vld` high for a single system-clock cycle.

A sync pulse locates the byte grid. Its position is fixed and cannot be programmed. The cycle that carries the pulse also carries the final bit (the LSB) of the last byte of the previous frame. That byte is completed and emitted, and the next enabled bit starts a fresh byte. A static mode input states what the pulse marks: a frame, a multiframe or a single byte. When concatenation mode is on, the pulse is always taken as a multiframe boundary, whatever the mode input says. In frame and multiframe interpretation, the first full byte after each pulse is tagged with `frame_start`. A pulse that lands in the middle of a byte raises `align_err`, drops the partial byte and realigns the grid.

Top module: `serial_byte_aligner`

## Requirements
- R1: While `rst` is high and after it falls, `byte_vld`, `frame_start` and `align_err` are 0 and `byte_out` is 0. Until the first accepted sync pulse the block is unaligned and emits no byte, whatever bits arrive.
- R2: `bit_in` is taken only in cycles with `bit_en` high. Any number of disabled cycles between bits leaves the assembled byte value and its completion point unchanged.
- R3: Bits enter most-significant first. The first enabled bit of a byte becomes `byte_out[7]` and the eighth becomes `byte_out[0]`.
- R4: Take an enabled cycle with `sync_in` high when seven bits of the current byte have already been collected. The bit in that cycle completes the byte, and the byte is emitted.
- R5: Every accepted sync pulse restarts the bit count, so the next enabled bit becomes the MSB of a new byte. This holds even when the pulse was misplaced.
- R6: An accepted sync pulse that arrives after the block is aligned, but with other than seven bits collected, drives `align_err` high for one cycle. No byte is emitted for that partial data.
- R7: `byte_vld` is high for exactly one cycle per completed byte, in the cycle after the edge that took its last bit. `byte_out` holds its value until the next byte completes.
- R8: With `bnd_mode` 2'b00 (frame) or 2'b01 (multiframe), `frame_start` is high together with `byte_vld` for the first full byte after each sync pulse. It is low for the byte that the sync bit itself completes.
- R9: With `bnd_mode` 2'b10 or 2'b11 (byte boundary) and `concat_en` low, `frame_start` never rises.
- R10: With `concat_en` high, sync pulses are treated as multiframe boundaries and R8 applies, even when `bnd_mode` selects byte boundary.
- R11: `sync_in` is ignored in cycles with `bit_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Receive-clock enable; one serial bit per high cycle |
| bit_in | input | 1 | Serial data bit |
| sync_in | input | 1 | Boundary pulse, valid only with `bit_en` |
| bnd_mode | input | 2 | 00 frame, 01 multiframe, 10/11 byte boundary |
| concat_en | input | 1 | Forces multiframe interpretation of sync |
| byte_out | output | BYTE_W | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe per completed byte |
| frame_start | output | 1 | First byte after a frame/multiframe boundary |
| align_err | output | 1 | Sync pulse arrived mid-byte |

## Verification
The hardest situation to reach is a sync pulse that lands inside a byte after alignment. On the same path, the first byte after realignment must still carry `frame_start`, while the byte closed by the sync bit must not. The bench first aligns the block with an isolated pulse and sends whole bytes. It then feeds three loose bits and pulses sync. It checks the error strobe, the dropped byte and the tag on the following byte. Disabled cycles with `sync_in` held high and with toggling data are interleaved with the bits, to show that gaps move neither the byte grid nor the boundary.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [1:0] {
        BND_FRAME    = 2'b00,
        BND_MFRAME   = 2'b01,
        BND_BYTE     = 2'b10,
        BND_BYTE_ALT = 2'b11
    } bnd_kind_e;

    typedef struct packed {
        logic complete;
        logic misalign;
        logic boundary;
    } sba_evt_t;

    function automatic bnd_kind_e resolve_kind(input logic concat, input logic [1:0] mode);
        if (concat) return BND_MFRAME;
        return bnd_kind_e'(mode);
    endfunction

    function automatic logic kind_tags_frame(input bnd_kind_e kind);
        return (kind == BND_FRAME) || (kind == BND_MFRAME);
    endfunction

endpackage

// File: rtl/sba_bit_counter.sv
module sba_bit_counter #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sync,
    output logic aligned,
    output logic complete,
    output logic misalign
);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             aligned_q;
    logic             at_last;

    assign at_last  = (cnt_q == LAST);
    assign aligned  = aligned_q;
    assign complete = en && aligned_q && at_last;
    assign misalign = en && sync && aligned_q && !at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            aligned_q <= 1'b0;
        end else if (en) begin
            if (sync) begin
                cnt_q     <= '0;
                aligned_q <= 1'b1;
            end else if (aligned_q) begin
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sba_shifter.sv
module sba_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    output logic [BYTE_W-1:0] word
);
    logic [BYTE_W-2:0] sh_q;

    assign word = {sh_q, din};

    always_ff @(posedge clk) begin
        if (rst)     sh_q <= '0;
        else if (en) sh_q <= word[BYTE_W-2:0];
    end
endmodule

// File: rtl/sba_boundary.sv
module sba_boundary
    import sba_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sync,
    input  logic       complete,
    input  logic       concat,
    input  logic [1:0] mode,
    output logic       tag
);
    bnd_kind_e kind;
    logic      pend_q;

    assign kind = resolve_kind(concat, mode);
    assign tag  = complete && pend_q && !sync;

    always_ff @(posedge clk) begin
        if (rst)                pend_q <= 1'b0;
        else if (en && sync)    pend_q <= kind_tags_frame(kind);
        else if (complete)      pend_q <= 1'b0;
    end
endmodule

// File: rtl/serial_byte_aligner.sv
module serial_byte_aligner
    import sba_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              sync_in,
    input  logic [1:0]        bnd_mode,
    input  logic              concat_en,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_start,
    output logic              align_err
);
    sba_evt_t          evt;
    logic              aligned_w;
    logic [BYTE_W-1:0] word_w;
    logic [BYTE_W-1:0] byte_q;
    sba_evt_t          evt_q;

    sba_bit_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (bit_en),
        .sync     (sync_in),
        .aligned  (aligned_w),
        .complete (evt.complete),
        .misalign (evt.misalign)
    );

    sba_shifter #(.BYTE_W(BYTE_W)) u_shf (
        .clk  (clk),
        .rst  (rst),
        .en   (bit_en),
        .din  (bit_in),
        .word (word_w)
    );

    sba_boundary u_bnd (
        .clk      (clk),
        .rst      (rst),
        .en       (bit_en),
        .sync     (sync_in),
        .complete (evt.complete),
        .concat   (concat_en),
        .mode     (bnd_mode),
        .tag      (evt.boundary)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            evt_q  <= '0;
        end else begin
            evt_q <= evt;
            if (evt.complete) byte_q <= word_w;
        end
    end

    assign byte_out    = byte_q;
    assign byte_vld    = evt_q.complete;
    assign frame_start = evt_q.boundary;
    assign align_err   = evt_q.misalign;
endmodule

// File: rtl/serial_byte_aligner_chk.sv
module serial_byte_aligner_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              aligned_w,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_vld,
    input logic              frame_start,
    input logic              align_err
);
    p_unaligned_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !aligned_w |-> !byte_vld);

    p_gap_no_byte_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_en) |-> !byte_vld);

    p_err_drops_byte_r6: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !byte_vld);

    p_vld_single_r7: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    p_hold_data_r7: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> $stable(byte_out));

    p_tag_with_byte_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> byte_vld);
endmodule

bind serial_byte_aligner serial_byte_aligner_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .aligned_w   (aligned_w),
    .byte_out    (byte_out),
    .byte_vld    (byte_vld),
    .frame_start (frame_start),
    .align_err   (align_err)
);

// File: tb/serial_byte_aligner_test.sv
module serial_byte_aligner_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       sync_in = 1'b0;
    logic [1:0] bnd_mode = 2'b00;
    logic       concat_en = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       frame_start;
    logic       align_err;

    int checks = 0;
    int failures = 0;
    logic [7:0] last_byte = 8'h00;

    always #2.5 clk = ~clk;

    serial_byte_aligner #(.BYTE_W(8)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .sync_in(sync_in), .bnd_mode(bnd_mode), .concat_en(concat_en),
        .byte_out(byte_out), .byte_vld(byte_vld),
        .frame_start(frame_start), .align_err(align_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle, sample outputs shortly after the consuming edge
    task automatic step(input bit en, input bit b, input bit s);
        @(negedge clk);
        bit_en  = en;
        bit_in  = b;
        sync_in = s;
        @(posedge clk);
        #1;
    endtask

    // send a byte MSB first; gap disabled cycles (sync held high) before each bit
    task automatic send_byte(input logic [7:0] d, input bit sync_last, input int gap,
                             input bit exp_fs, input string req);
        int early_vld = 0;
        int errs = 0;
        for (int i = 7; i >= 0; i--) begin
            for (int g = 0; g < gap; g++) begin
                step(1'b0, ~d[i], 1'b1);
                if (byte_vld) early_vld++;
                if (align_err) errs++;
            end
            step(1'b1, d[i], sync_last && (i == 0));
            if (i != 0 && byte_vld) early_vld++;
            if (align_err) errs++;
        end
        chk(early_vld == 0, {req, " no early byte_vld"}, early_vld, 0);
        chk(errs == 0, {req, " no align_err"}, errs, 0);
        chk(byte_vld == 1'b1, {req, " byte_vld"}, byte_vld, 1);
        chk(byte_out == d, {req, " byte_out"}, byte_out, d);
        chk(frame_start == exp_fs, {req, " frame_start"}, frame_start, exp_fs);
        last_byte = d;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) step(1'b1, 1'b1, 1'b0);
        chk(byte_vld == 0 && frame_start == 0 && align_err == 0, "R1 flags in reset",
            {byte_vld, frame_start, align_err}, 0);
        chk(byte_out == 8'h00, "R1 byte_out in reset", byte_out, 0);
        @(negedge clk);
        rst = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                step(1'b1, i[0], 1'b0);
                if (byte_vld || align_err) seen++;
            end
            chk(seen == 0, "R1 unaligned emits nothing", seen, 0);
        end
        step(1'b1, 1'b1, 1'b1);
        chk(byte_vld == 0 && align_err == 0, "R1 first sync aligns quietly",
            {byte_vld, align_err}, 0);
    endtask

    task automatic t_basic;
        send_byte(8'hA5, 1'b0, 0, 1'b1, "R3 R8 first byte after sync");
        send_byte(8'h3C, 1'b0, 2, 1'b0, "R2 R11 gapped byte with sync in gaps");
    endtask

    task automatic t_hold;
        step(1'b0, 1'b1, 1'b0);
        chk(byte_vld == 0, "R7 byte_vld single cycle", byte_vld, 0);
        chk(byte_out == last_byte, "R7 byte_out held", byte_out, last_byte);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk(byte_out == last_byte, "R7 byte_out held mid-byte", byte_out, last_byte);
        // realign the two stray bits away via a misplaced sync is covered later;
        // here finish the stray byte so the grid stays intact
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0);
        chk(byte_vld == 1 && byte_out == 8'h80, "R7 byte after hold", byte_out, 8'h80);
    endtask

    task automatic t_sync_last;
        send_byte(8'h81, 1'b1, 0, 1'b0, "R4 R8 byte closed by sync bit");
        send_byte(8'h5A, 1'b0, 1, 1'b1, "R8 first byte of new frame");
    endtask

    task automatic t_misalign;
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk(align_err == 1, "R6 align_err on mid-byte sync", align_err, 1);
        chk(byte_vld == 0, "R6 partial byte dropped", byte_vld, 0);
        step(1'b0, 1'b0, 1'b0);
        chk(align_err == 0, "R6 align_err one cycle", align_err, 0);
        send_byte(8'h96, 1'b0, 0, 1'b1, "R5 realigned byte after bad sync");
    endtask

    task automatic t_byte_mode;
        bnd_mode = 2'b10;
        send_byte(8'h11, 1'b1, 0, 1'b0, "R9 byte mode sync byte");
        send_byte(8'h22, 1'b0, 0, 1'b0, "R9 byte mode no frame_start");
        bnd_mode = 2'b11;
        send_byte(8'h77, 1'b1, 0, 1'b0, "R9 alt byte code sync byte");
        send_byte(8'h88, 1'b0, 0, 1'b0, "R9 alt byte code no frame_start");
    endtask

    task automatic t_concat;
        bnd_mode  = 2'b10;
        concat_en = 1'b1;
        send_byte(8'h33, 1'b1, 0, 1'b0, "R10 concat sync byte");
        send_byte(8'h44, 1'b0, 0, 1'b1, "R10 concat forces boundary");
        concat_en = 1'b0;
    endtask

    task automatic t_mframe;
        bnd_mode = 2'b01;
        send_byte(8'h55, 1'b1, 3, 1'b0, "R8 multiframe sync byte");
        send_byte(8'hC3, 1'b0, 0, 1'b1, "R8 multiframe boundary");
        send_byte(8'hE7, 1'b0, 0, 1'b0, "R8 second byte untagged");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_sync_last();
        t_misalign();
        t_byte_mode();
        t_concat();
        t_mframe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule